// File: doc/BRIEF.md
# Reversible Phase-Shifted Multilevel Gate Modulator

This block produces the gate commands for one phase leg of an N-level flying-capacitor converter. The leg has N−1 complementary switch pairs. Each pair owns a triangular carrier, and the carriers are spread evenly in phase over one carrier period. The block compares a single duty reference with every carrier and drives a top gate and a bottom gate for each pair, with a programmable dead band between them. The phase spread places the switch-node ripple at N−1 times the carrier frequency, which keeps the flying capacitors charged evenly.

The duty reference is compared continuously against the live carrier values and is not latched at a period boundary, so a new command reaches the gates on the next clock edge. At a 125 MHz clock that delay is 8 ns. A reverse input serves fault-current reset. While it is high, every carrier position counter counts down instead of up and every carrier value is inverted, so the pairs repeat their recent switching backwards in time and in complementary form. Carrier positions are never reloaded when the direction changes, so the phase relationships between pairs survive any number of reversals.

Two state machines shape the behaviour. The direction machine has the states FORWARD and BACKWARD. It takes the transition FORWARD→BACKWARD on an edge that samples `reverse` high and BACKWARD→FORWARD on an edge that samples it low. Each pair has a gate machine with five states: HOLD (after reset, both gates off), LOW (bottom on), RISE (both off, dead band before top), HIGH (top on) and FALL (both off, dead band before bottom). The transitions are:
- HOLD→RISE or HOLD→FALL, according to the demand, or HOLD→HIGH or HOLD→LOW directly when the dead band is zero.
- LOW→RISE (or LOW→HIGH when the dead band is zero) when the demand goes high.
- HIGH→FALL (or HIGH→LOW) when the demand goes low.
- RISE→HIGH and FALL→LOW when the dead band expires.
- RISE→FALL and FALL→RISE when the demand flips back during a dead band.

Top module: `fcpwm_phase_leg`

## Requirements
- R1: With P = LEVELS−1 pairs and carrier half-period H, pair k starts after reset at position k·2H/P in a 0..2H−1 position cycle (2H must be a multiple of P). Position p gives the carrier value p when p < H and 2H−1−p otherwise.
- R2: The reference level is ref = floor(duty·H / 2^FRAC), and pair k demands its top gate while ref > carrier. With zero dead band, each top gate is high for exactly 2·ref of every 2H cycles.
- R3: A duty above 2^FRAC (the value 1.0) acts as exactly 2^FRAC, which holds every top gate high permanently when the dead band is zero.
- R4: A change of duty is reflected in the gates at the next clock edge, at any point of the carrier period.
- R5: At each edge that samples `reverse` high, every position steps down by one (wrapping 0→2H−1) instead of up. After that edge the compared carrier value is H−1−v, where v is the value at that position. When `reverse` returns low, counting resumes upward from the current positions, and no position is ever reloaded.
- R6: A top gate turns on only after its demand has been high at dead_cycles+1 consecutive edges, and a bottom gate turns on only after its demand has been low at dead_cycles+1 consecutive edges. Both gates are off in between.
- R7: The top and bottom gates of a pair are never high in the same cycle.
- R8: While `rst` is high, all gates are low. The first edge after reset leaves HOLD according to the demand at that edge.
- R9: A duty of 2^(FRAC−1) (the value 0.5) keeps each top gate high for exactly half of every carrier period, which gives zero average output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst | input | 1 | Synchronous reset, active high |
| duty | input | DUTY_W | Unsigned duty, FRAC fractional bits |
| dead_cycles | input | DT_W | Dead band length in clock cycles |
| reverse | input | 1 | High: count carriers backward and invert them |
| gate_hi | output | LEVELS−1 | Top gate per switch pair |
| gate_lo | output | LEVELS−1 | Bottom gate per switch pair |

## Verification
The hardest situation to reach is a dead band that is interrupted: the demand flips back while a pair is in RISE or FALL. The same difficulty arises when `reverse` toggles in the middle of a carrier slope, which cuts demand runs short at arbitrary phases. The stimulus reaches these cases with the small configuration (five levels, H = 8). It toggles `reverse` every few cycles and combines non-zero dead bands with duties near the carrier extremes. The bench tracks every pair's position and the length of its current demand run arithmetically, so each interrupted or resumed dead band is predicted exactly, cycle by cycle.

// File: rtl/fcpwm_pkg.sv
package fcpwm_pkg;

    typedef enum logic [0:0] {
        DIR_FWD,
        DIR_REV
    } dir_t;

    typedef enum logic [2:0] {
        GS_HOLD,
        GS_LOW,
        GS_RISE,
        GS_HIGH,
        GS_FALL
    } gate_st_t;

    function automatic int unsigned phase_start(input int unsigned idx,
                                                input int unsigned pairs,
                                                input int unsigned half);
        return (idx * 2 * half) / pairs;
    endfunction

endpackage

// File: rtl/fcpwm_carrier.sv
module fcpwm_carrier #(
    parameter int unsigned HALF  = 64,
    parameter int unsigned START = 0,
    localparam int CW = $clog2(HALF),
    localparam int PW = $clog2(2 * HALF)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step_back,
    input  logic          invert,
    input  logic [CW:0]   ref_lvl,
    output logic          demand
);
    localparam logic [PW-1:0] LAST_P  = PW'(2 * HALF - 1);
    localparam logic [PW-1:0] START_P = PW'(START);
    localparam logic [CW-1:0] TOP_V   = CW'(HALF - 1);

    logic [PW-1:0] pos;
    logic [PW-1:0] mirror;
    logic [CW-1:0] tri_v;
    logic [CW-1:0] eff;

    // position counter: up in forward mode, down in reverse, never reloaded
    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= START_P;
        end else if (step_back) begin
            pos <= (pos == '0) ? LAST_P : pos - 1'b1;
        end else begin
            pos <= (pos == LAST_P) ? '0 : pos + 1'b1;
        end
    end

    always_comb begin
        mirror = LAST_P - pos;
        tri_v  = (pos < PW'(HALF)) ? CW'(pos) : CW'(mirror);
        eff    = invert ? (TOP_V - tri_v) : tri_v;
        demand = ({1'b0, eff} < ref_lvl);
    end

    // R5 / R1: with the inversion unchanged the carrier moves by at most one step
    a_r5_carrier_continuity: assert property (@(posedge clk) disable iff (rst)
        $stable(invert) |->
            ((eff >= $past(eff)) ? (eff - $past(eff)) : ($past(eff) - eff)) <= CW'(1));

endmodule

// File: rtl/fcpwm_deadband.sv
module fcpwm_deadband #(
    parameter int DT_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            demand,
    input  logic [DT_W-1:0] dead_len,
    output logic            hi,
    output logic            lo
);
    import fcpwm_pkg::*;

    gate_st_t        st, st_n;
    logic [DT_W-1:0] cnt, cnt_n;
    logic            no_gap;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= GS_HOLD;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    // next state
    always_comb begin
        no_gap = (dead_len == '0);
        st_n   = st;
        cnt_n  = cnt;
        unique case (st)
            GS_HOLD, GS_LOW: begin
                if (demand) begin
                    st_n  = no_gap ? GS_HIGH : GS_RISE;
                    cnt_n = DT_W'(1);
                end else if (st == GS_HOLD) begin
                    st_n  = no_gap ? GS_LOW : GS_FALL;
                    cnt_n = DT_W'(1);
                end
            end
            GS_HIGH: begin
                if (!demand) begin
                    st_n  = no_gap ? GS_LOW : GS_FALL;
                    cnt_n = DT_W'(1);
                end
            end
            GS_RISE: begin
                if (!demand) begin
                    st_n  = no_gap ? GS_LOW : GS_FALL;
                    cnt_n = DT_W'(1);
                end else if (cnt >= dead_len) begin
                    st_n = GS_HIGH;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            GS_FALL: begin
                if (demand) begin
                    st_n  = no_gap ? GS_HIGH : GS_RISE;
                    cnt_n = DT_W'(1);
                end else if (cnt >= dead_len) begin
                    st_n = GS_LOW;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            default: begin
                st_n  = GS_HOLD;
                cnt_n = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        hi = (st == GS_HIGH);
        lo = (st == GS_LOW);
    end

    // R7: complementary gates never overlap
    a_r7_never_both: assert property (@(posedge clk) disable iff (rst) !(hi && lo));

    // R6: a non-zero dead band leaves both gates off before either turns on
    a_r6_gap_before_hi: assert property (@(posedge clk) disable iff (rst)
        (dead_len != '0 && $rose(hi)) |-> !$past(lo));
    a_r6_gap_before_lo: assert property (@(posedge clk) disable iff (rst)
        (dead_len != '0 && $rose(lo)) |-> !$past(hi));

    // R6: the top gate only rises on a sampled demand
    a_r6_hi_needs_demand: assert property (@(posedge clk) disable iff (rst)
        $rose(hi) |-> $past(demand));

endmodule

// File: rtl/fcpwm_phase_leg.sv
module fcpwm_phase_leg #(
    parameter int LEVELS = 5,
    parameter int HALF   = 64,
    parameter int FRAC   = 8,
    parameter int DUTY_W = 10,
    parameter int DT_W   = 4,
    localparam int PAIRS = LEVELS - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DUTY_W-1:0] duty,
    input  logic [DT_W-1:0]   dead_cycles,
    input  logic              reverse,
    output logic [PAIRS-1:0]  gate_hi,
    output logic [PAIRS-1:0]  gate_lo
);
    import fcpwm_pkg::*;

    localparam int CW     = $clog2(HALF);
    localparam int ONE    = 1 << FRAC;
    localparam int PROD_W = DUTY_W + CW + 1;

    dir_t               mode_q, mode_n;
    logic               invert;
    logic [DUTY_W-1:0]  duty_c;
    logic [CW:0]        ref_lvl;
    logic [PAIRS-1:0]   demand;

    // direction state register
    always_ff @(posedge clk) begin
        if (rst) mode_q <= DIR_FWD;
        else     mode_q <= mode_n;
    end

    // direction next state
    always_comb begin
        mode_n = mode_q;
        unique case (mode_q)
            DIR_FWD: if (reverse)  mode_n = DIR_REV;
            DIR_REV: if (!reverse) mode_n = DIR_FWD;
        endcase
    end

    // direction outputs
    always_comb begin
        invert = (mode_q == DIR_REV);
    end

    // clamp to 1.0 and scale onto the carrier range
    always_comb begin
        duty_c  = (duty > DUTY_W'(ONE)) ? DUTY_W'(ONE) : duty;
        ref_lvl = (CW+1)'((PROD_W'(duty_c) * PROD_W'(HALF)) >> FRAC);
    end

    for (genvar k = 0; k < PAIRS; k++) begin : g_pair
        fcpwm_carrier #(
            .HALF  (HALF),
            .START (fcpwm_pkg::phase_start(k, PAIRS, HALF))
        ) u_car (
            .clk       (clk),
            .rst       (rst),
            .step_back (reverse),
            .invert    (invert),
            .ref_lvl   (ref_lvl),
            .demand    (demand[k])
        );

        fcpwm_deadband #(
            .DT_W (DT_W)
        ) u_db (
            .clk      (clk),
            .rst      (rst),
            .demand   (demand[k]),
            .dead_len (dead_cycles),
            .hi       (gate_hi[k]),
            .lo       (gate_lo[k])
        );
    end

    // R5: the direction follows the reverse request from the next edge
    a_r5_mode_follow: assert property (@(posedge clk) disable iff (rst)
        reverse |=> invert);
    a_r5_mode_return: assert property (@(posedge clk) disable iff (rst)
        !reverse |=> !invert);

    // R3: the scaled reference never exceeds the carrier span
    a_r3_ref_cap: assert property (@(posedge clk) disable iff (rst)
        ref_lvl <= (CW+1)'(HALF));

    // R8: gates are released only after reset
    a_r8_quiet_in_reset: assert property (@(posedge clk)
        $past(rst) |-> (gate_hi == '0 && gate_lo == '0));

endmodule

// File: tb/fcpwm_phase_leg_test.sv
module fcpwm_phase_leg_test;
    localparam int LV   = 5;
    localparam int H    = 8;
    localparam int FR   = 3;
    localparam int DW   = 5;
    localparam int TW   = 3;
    localparam int P    = LV - 1;
    localparam int TWOH = 2 * H;
    localparam int ONE  = 1 << FR;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] duty = '0;
    logic [TW-1:0] dead = '0;
    logic          rev = 1'b0;
    logic [P-1:0]  ghi, glo;

    always #10 clk = ~clk;

    fcpwm_phase_leg #(
        .LEVELS (LV), .HALF (H), .FRAC (FR), .DUTY_W (DW), .DT_W (TW)
    ) uut (
        .clk (clk), .rst (rst), .duty (duty), .dead_cycles (dead),
        .reverse (rev), .gate_hi (ghi), .gate_lo (glo)
    );

    int nvec = 0;
    int nbad = 0;
    bit done = 1'b0;
    int pos_m [P];
    bit mode_m;
    int run_t [P];
    int run_f [P];
    int hcount [P];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // reset with given settings, check quiet gates, seed the model (R8, R1)
    task automatic start(input int d, input int t, input bit r);
        @(negedge clk);
        rst  = 1'b1;
        duty = DW'(d);
        dead = TW'(t);
        rev  = r;
        repeat (2) @(negedge clk);
        check((ghi | glo) == '0, "R8", "gates in reset", int'(ghi | glo), 0);
        for (int k = 0; k < P; k++) begin
            pos_m[k]  = k * TWOH / P;
            run_t[k]  = 0;
            run_f[k]  = 0;
            hcount[k] = 0;
        end
        mode_m = 1'b0;
        rst = 1'b0;
    endtask

    // one clock: predict, advance model, compare (called at a negedge)
    task automatic cyc(input string req);
        int refv;
        int c;
        logic [P-1:0] et, eb;
        refv = (int'(duty) > ONE) ? ONE : int'(duty);
        refv = refv * H / ONE;
        for (int k = 0; k < P; k++) begin
            c = (pos_m[k] < H) ? pos_m[k] : (TWOH - 1 - pos_m[k]);
            if (mode_m) c = H - 1 - c;
            if (refv > c) begin
                run_t[k]++;
                run_f[k] = 0;
            end else begin
                run_f[k]++;
                run_t[k] = 0;
            end
            et[k] = (run_t[k] >= int'(dead) + 1);
            eb[k] = (run_f[k] >= int'(dead) + 1);
        end
        @(posedge clk);
        for (int k = 0; k < P; k++)
            pos_m[k] = rev ? (pos_m[k] + TWOH - 1) % TWOH : (pos_m[k] + 1) % TWOH;
        mode_m = rev;
        @(negedge clk);
        check(ghi == et, req, "gate_hi", int'(ghi), int'(et));
        check(glo == eb, req, "gate_lo", int'(glo), int'(eb));
        check((ghi & glo) == '0, "R7", "overlap", int'(ghi & glo), 0);
        for (int k = 0; k < P; k++) hcount[k] += int'(ghi[k]);
    endtask

    initial begin
        // R1, R2, R3, R9: duty sweep including values above 1.0
        for (int d = 0; d <= 12; d++) begin
            string tag;
            int lim;
            tag = (d > ONE) ? "R3" : ((d == ONE / 2) ? "R9" : "R2");
            lim = (d > ONE) ? ONE : d;
            start(d, 0, 1'b0);
            cyc("R1");
            for (int k = 0; k < P; k++) hcount[k] = 0;
            repeat (TWOH) cyc(tag);
            for (int k = 0; k < P; k++)
                check(hcount[k] == 2 * lim * H / ONE, tag, "high cycles per period",
                      hcount[k], 2 * lim * H / ONE);
        end

        // R4: duty changes mid-period take effect at the next edge
        start(2, 0, 1'b0);
        repeat (5) cyc("R4");
        duty = DW'(6);
        repeat (3) cyc("R4");
        duty = DW'(1);
        repeat (4) cyc("R4");
        duty = DW'(7);
        repeat (9) cyc("R4");

        // R5: reverse mid-slope, hold, release, rapid toggling
        start(3, 0, 1'b0);
        repeat (7) cyc("R5");
        rev = 1'b1;
        repeat (20) cyc("R5");
        rev = 1'b0;
        repeat (10) cyc("R5");
        for (int i = 0; i < 8; i++) begin
            rev = ~rev;
            repeat (3) cyc("R5");
        end
        rev = 1'b1;
        repeat (2) cyc("R5");
        for (int k = 0; k < P; k++) hcount[k] = 0;
        duty = DW'(ONE / 2);
        repeat (TWOH) cyc("R9");
        for (int k = 0; k < P; k++)
            check(hcount[k] == H, "R9", "balanced under reverse", hcount[k], H);
        rev = 1'b0;

        // R6: dead bands with steady and reversed carriers
        for (int t = 1; t <= 3; t++) begin
            for (int j = 0; j < 5; j++) begin
                int dsel;
                dsel = (j == 0) ? 1 : ((j == 1) ? 3 : ((j == 2) ? 4 : ((j == 3) ? 6 : 8)));
                start(dsel, t, 1'b0);
                repeat (20) cyc("R6");
                rev = 1'b1;
                repeat (12) cyc("R6");
                rev = 1'b0;
                repeat (2) cyc("R6");
                rev = 1'b1;
                repeat (5) cyc("R6");
                rev = 1'b0;
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

endmodule